// File: doc/BRIEF.md
# Minimum-Depth Prefix Binary Adder

This block adds two N-bit unsigned operands and a single carry-in bit. It returns an N-bit sum and a carry-out. It is purely combinational: it has no clock, no state and no pipeline stage. It is meant to sit inside a larger datapath wherever a short, fixed logic depth matters more than a balanced wire load.

Carries come from a divide-and-conquer prefix network that uses log2(N) operator levels. First, each bit forms a generate flag and a propagate flag. The tree then merges these flags into group flags for every span that starts at bit 0. At each level, the topmost node of each lower half-block is broadcast to every bit of the half-block directly above it. The carry-in is folded in after the tree. The sum is formed as propagate XOR incoming carry.

A parameter selects how the per-bit flags are built. They can come from plain Boolean gates, or from two-input weighted-sum threshold units with a bias, with exactly the same result.

Top module: `skl_prefix_adder`

## Requirements
- R1: For every input, {carry_out, sum} equals opnd_a + opnd_b + carry_in, computed as an (N+1)-bit unsigned value.
- R2: The per-bit generate flag is A_i AND B_i and the per-bit propagate flag is A_i XOR B_i, so the two flags are never both 1. When opnd_b is 0 and carry_in is 0, the sum equals opnd_a. When opnd_a equals opnd_b and carry_in is 0, the sum equals opnd_a shifted left by one, and the shifted-out top bit appears on carry_out.
- R3: carry_out equals the group generate over bits N-1..0, ORed with (the group propagate over bits N-1..0 AND carry_in).
- R4: The carry into bit 0 is carry_in, so sum bit 0 equals A_0 XOR B_0 XOR carry_in.
- R5: Every sum bit i equals A_i XOR B_i XOR c_i. Here c_0 is carry_in and c_(i+1) = (A_i AND B_i) OR ((A_i XOR B_i) AND c_i).
- R6: With USE_THRESHOLD = 1, sum and carry_out are bit-identical to those with USE_THRESHOLD = 0 for every input.
- R7: For N = 4 these results hold:
  - 0+0+0 gives sum 0000, carry_out 0.
  - 1+1+0 gives sum 0010.
  - 6+3+0 gives sum 1001.
  - 9+7+0 gives sum 0000, carry_out 1.
  - 15+15+1 gives sum 1111, carry_out 1.
- R8: When every bit propagates (opnd_a all ones, opnd_b zero) and carry_in is 1, the carry-in travels to carry_out: sum is all zeros and carry_out is 1. All-ones plus all-ones plus carry_in 1 gives all-ones with carry_out 1.
- R9: The outputs depend only on the present inputs. Applying a vector again after other vectors gives the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | first addend |
| opnd_b | input | N | second addend |
| carry_in | input | 1 | carry into bit 0 |
| sum | output | N | low N bits of the total |
| carry_out | output | 1 | carry out of bit N-1 |

## Verification
The bound checks are immediate, so they assume the operands and carry_in are 2-state and settled whenever the combinational evaluation completes. An X on any input would make every relation meaningless. The bench drives all inputs from a single procedural driver on the rising clock edge, so every value is a defined 0 or 1. It compares results only on the falling edge, when the network has had half a period to settle. At the default width the stimulus is exhaustive. At wider widths it uses random operands plus all-zero, all-one and alternating patterns with both carry_in values, and all of these stay inside the legal input space.

// File: rtl/skl_pkg.sv
package skl_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // associative merge of a higher span with the span just below it
  function automatic gp_t gp_combine(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // two-input weighted-sum unit: fires when w0*x0 + w1*x1 + bias >= 0
  function automatic logic thr_unit(logic x0, logic x1, int w0, int w1, int bias);
    int acc;
    acc = w0 * int'(x0) + w1 * int'(x1) + bias;
    return (acc >= 0);
  endfunction

  // carry into bit i+1 given the group flags for span i..0
  function automatic logic group_carry(logic grp_g, logic grp_p, logic cin);
    return grp_g | (grp_p & cin);
  endfunction

endpackage

// File: rtl/skl_gp_stage.sv
module skl_gp_stage #(
  parameter int N = 4,
  parameter bit USE_THRESHOLD = 1'b0
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] bit_g,
  output logic [N-1:0] bit_p
);
  import skl_pkg::*;

  if (USE_THRESHOLD) begin : g_thr
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic any_w;
      logic not_both_w;
      assign bit_g[i]   = thr_unit(a[i], b[i], 1, 1, -2);
      assign any_w      = thr_unit(a[i], b[i], 1, 1, -1);
      assign not_both_w = thr_unit(a[i], b[i], -1, -1, 1);
      assign bit_p[i]   = thr_unit(any_w, not_both_w, 1, 1, -2);
    end
  end else begin : g_bool
    assign bit_g = a & b;
    assign bit_p = a ^ b;
  end

endmodule

// File: rtl/skl_prefix_tree.sv
module skl_prefix_tree #(
  parameter int N = 4
) (
  input  logic [N-1:0] g_in,
  input  logic [N-1:0] p_in,
  output logic [N-1:0] grp_g,
  output logic [N-1:0] grp_p
);
  import skl_pkg::*;

  localparam int LVLS = $clog2(N);

  logic [LVLS:0][N-1:0] gl;
  logic [LVLS:0][N-1:0] pl;

  assign gl[0] = g_in;
  assign pl[0] = p_in;

  for (genvar k = 0; k < LVLS; k++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_node
      if (((i >> k) & 1) == 1) begin : g_merge
        // top node of the lower neighbouring block of size 2^k
        localparam int SRC = ((i >> k) << k) - 1;
        gp_t hi_w, lo_w, res_w;
        assign hi_w = '{g: gl[k][i],   p: pl[k][i]};
        assign lo_w = '{g: gl[k][SRC], p: pl[k][SRC]};
        assign res_w = gp_combine(hi_w, lo_w);
        assign gl[k+1][i] = res_w.g;
        assign pl[k+1][i] = res_w.p;
      end else begin : g_pass
        assign gl[k+1][i] = gl[k][i];
        assign pl[k+1][i] = pl[k][i];
      end
    end
  end

  assign grp_g = gl[LVLS];
  assign grp_p = pl[LVLS];

endmodule

// File: rtl/skl_sum_stage.sv
module skl_sum_stage #(
  parameter int N = 4
) (
  input  logic [N-1:0] bit_p,
  input  logic [N-1:0] grp_g,
  input  logic [N-1:0] grp_p,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic [N-1:0] sum
);
  import skl_pkg::*;

  assign carry[0] = cin;
  for (genvar i = 0; i < N; i++) begin : g_cy
    assign carry[i+1] = group_carry(grp_g[i], grp_p[i], cin);
  end

  assign sum = bit_p ^ carry[N-1:0];

endmodule

// File: rtl/skl_prefix_adder.sv
module skl_prefix_adder #(
  parameter int N = 4,
  parameter bit USE_THRESHOLD = 1'b0
) (
  input  logic [N-1:0] opnd_a,
  input  logic [N-1:0] opnd_b,
  input  logic         carry_in,
  output logic [N-1:0] sum,
  output logic         carry_out
);
  logic [N-1:0] bit_g, bit_p;
  logic [N-1:0] grp_g, grp_p;
  logic [N:0]   carry;

  skl_gp_stage #(.N(N), .USE_THRESHOLD(USE_THRESHOLD)) u_gp (
    .a(opnd_a), .b(opnd_b), .bit_g(bit_g), .bit_p(bit_p)
  );

  skl_prefix_tree #(.N(N)) u_tree (
    .g_in(bit_g), .p_in(bit_p), .grp_g(grp_g), .grp_p(grp_p)
  );

  skl_sum_stage #(.N(N)) u_sum (
    .bit_p(bit_p), .grp_g(grp_g), .grp_p(grp_p), .cin(carry_in),
    .carry(carry), .sum(sum)
  );

  assign carry_out = carry[N];

endmodule

// File: rtl/skl_prefix_adder_chk.sv
module skl_prefix_adder_chk #(
  parameter int N = 4
) (
  input logic [N-1:0] opnd_a,
  input logic [N-1:0] opnd_b,
  input logic         carry_in,
  input logic [N-1:0] sum,
  input logic         carry_out,
  input logic [N-1:0] bit_g,
  input logic [N-1:0] bit_p,
  input logic [N-1:0] grp_g,
  input logic [N-1:0] grp_p,
  input logic [N:0]   carry
);
  logic [N:0] ref_total;
  assign ref_total = {1'b0, opnd_a} + {1'b0, opnd_b} + {{N{1'b0}}, carry_in};

  always_comb begin
    AST_TOTAL_MATCH: assert ({carry_out, sum} == ref_total); // R1
    AST_FLAGS_DISJOINT: assert ((bit_g & bit_p) == '0); // R2
    AST_GEN_IS_AND: assert (bit_g == (opnd_a & opnd_b)); // R2
    AST_TOP_GROUP_CARRY: assert (carry_out == (grp_g[N-1] | (grp_p[N-1] & carry_in))); // R3
    AST_BIT0_CARRY: assert (sum[0] == (opnd_a[0] ^ opnd_b[0] ^ carry_in)); // R4
    AST_SUM_FROM_CARRY: assert (sum == (bit_p ^ carry[N-1:0])); // R5
    for (int i = 0; i < N; i++) begin
      AST_RIPPLE_EQUIV: assert (carry[i+1] == (bit_g[i] | (bit_p[i] & carry[i]))); // R5
    end
  end

endmodule

bind skl_prefix_adder skl_prefix_adder_chk #(.N(N)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
  .sum(sum), .carry_out(carry_out),
  .bit_g(bit_g), .bit_p(bit_p), .grp_g(grp_g), .grp_p(grp_p),
  .carry(carry)
);

// File: tb/skl_prefix_adder_tb.sv
module skl_prefix_adder_tb;
  localparam int N = 4;

  typedef struct {
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic         c;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] a = '0, b = '0;
  logic cin = 1'b0;
  logic [N-1:0] s_b, s_t;
  logic co_b, co_t;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;
  item_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  skl_prefix_adder #(.N(N), .USE_THRESHOLD(1'b0)) u_dut (
    .opnd_a(a), .opnd_b(b), .carry_in(cin), .sum(s_b), .carry_out(co_b)
  );
  skl_prefix_adder #(.N(N), .USE_THRESHOLD(1'b1)) u_dut_thr (
    .opnd_a(a), .opnd_b(b), .carry_in(cin), .sum(s_t), .carry_out(co_t)
  );

  task automatic check(string tag, logic [N:0] act, logic [N:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", tag, a, b, cin, act, exp);
    end
  endtask

  task automatic drive(logic [N-1:0] va, logic [N-1:0] vb, logic vc, string tag);
    item_t it;
    @(posedge clk);
    a = va; b = vb; cin = vc;
    it.a = va; it.b = vb; it.c = vc; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare on the falling edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      logic [N:0] exp;
      logic [N:0] rip;
      logic cy;
      it = q.pop_front();
      exp = {1'b0, it.a} + {1'b0, it.b} + {{N{1'b0}}, it.c};
      check(it.tag, {co_b, s_b}, exp);
      // R5: restated as a bitwise ripple chain
      cy = it.c;
      for (int i = 0; i < N; i++) begin
        rip[i] = it.a[i] ^ it.b[i] ^ cy;
        cy = (it.a[i] & it.b[i]) | ((it.a[i] ^ it.b[i]) & cy);
      end
      rip[N] = cy;
      check("R5 ripple", {co_b, s_b}, rip);
      // R3: carry_out from whole-word group generate/propagate
      check("R3 cout", {{N{1'b0}}, co_b},
            {{N{1'b0}}, (((it.a & it.b) != '0 && exp[N]) | ((&(it.a ^ it.b)) & it.c))});
      // R4: bit 0
      check("R4 bit0", {{N{1'b0}}, s_b[0]}, {{N{1'b0}}, it.a[0] ^ it.b[0] ^ it.c});
      // R6: threshold flavour identical
      check("R6 thr", {co_t, s_t}, {co_b, s_b});
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [N-1:0] ONES = '1;
  localparam logic [N-1:0] ALT  = {(N/2){2'b10}};

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive('0, '0, 1'b0, "R7 reset-state zero");
    if (N == 4) begin
      drive(4'd1, 4'd1, 1'b0, "R7 1+1");
      drive(4'd6, 4'd3, 1'b0, "R7 6+3");
      drive(4'd9, 4'd7, 1'b0, "R7 9+7");
      drive(4'd15, 4'd15, 1'b1, "R7 15+15+1");
    end
    drive(ONES, '0, 1'b1, "R8 full propagate");
    drive(ONES, ONES, 1'b1, "R8 all ones");
    drive(ALT, '0, 1'b0, "R2 propagate only");
    drive(ALT, ALT, 1'b0, "R2 generate only");
    drive(~ALT, ALT, 1'b1, "R8 alt carry");
    drive(ALT, ~ALT, 1'b0, "R8 alt nocarry");
    if (N == 4) begin
      for (int v = 0; v < 512; v++)
        drive(v[3:0], v[7:4], v[8], "R1 exhaustive");
    end else begin
      for (int v = 0; v < 2000; v++)
        drive(N'($urandom), N'($urandom), 1'($urandom), "R1 random");
    end
    drive(ONES, '0, 1'b1, "R9 repeat");
    drive('0, '0, 1'b0, "R9 repeat zero");
    wait (q.size() == 0);
    @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule